// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

A general-purpose I/O port of up to 32 pins, controlled through a plain register read/write bus. Software sets the output level of every pin and which pins drive, reads back the levels actually present on all pins, and configures a per-pin interrupt source. The port drives the output values and output enables toward the pads. It samples the pad inputs through a two-stage synchroniser and raises one combined interrupt line.

Each pin's interrupt is selected by two bits. A type bit chooses edge or level sensitivity. A polarity bit chooses rising/high or falling/low. Edge events are captured in a pending flag that stays set until software writes a one for that pin to the end-of-interrupt register. Level interrupts track the synchronised input directly and are never captured. Interrupts on both edges are not offered.

Bus reads are registered: read data appears one cycle after the read strobe and holds until the next read. Registers sit at byte offsets. Pin data is at 0x00 and direction at 0x04. The interrupt group starts at 0x30: enable 0x30, type 0x34, polarity 0x38, status 0x3C, end-of-interrupt 0x40. The pin level view is at 0x44.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset every register is zero: all pins are inputs (`gpio_oe`=0), `gpio_out`=0, all interrupts are disabled, `irq`=0 and `bus_rdata`=0.
- R2: A write to offset 0x00 sets `gpio_out` to the written word on the next clock, and the value holds until the next write there; reading 0x00 returns it.
- R3: A write to offset 0x04 sets `gpio_oe`; a bit of 1 makes that pin an output and 0 makes it an input; reading 0x04 returns it.
- R4: Reading offset 0x44 returns the pin levels after a two-flop synchroniser (a level applied before clock edge k is visible to a read issued at edge k+2), for every pin regardless of direction.
- R5: With enable (0x30), type (0x34) and polarity (0x38) bits all 1, a rising edge on the synchronised input sets a pending flag that stays set after the pin falls again and shows in status (0x3C).
- R6: With type 1 and polarity 0, a falling edge sets the pending flag; a rising edge does not.
- R7: With type 0, the status bit equals the enabled live synchronised level (active high for polarity 1, active low for polarity 0), is not latched, and a write to end-of-interrupt has no effect on it.
- R8: Writing a mask to offset 0x40 clears the pending flag of each pin whose mask bit is 1 and leaves the others unchanged.
- R9: An edge detected in the same cycle as an end-of-interrupt write for that pin leaves the flag set.
- R10: A pin whose enable bit is 0 never shows a status bit; clearing the enable bit (or the type bit) of a pin drops its pending flag.
- R11: `irq` is the OR of all status bits, registered, so it follows the status one clock later.
- R12: Status (0x3C) and pin levels (0x44) are read-only; end-of-interrupt reads as zero; unmapped offsets read as zero and writes to them change nothing.
- R13: `bus_rdata` is updated only on the clock after a read strobe and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| gpio_in | input | W | Pad input levels (asynchronous) |
| gpio_out | output | W | Output data to pads |
| gpio_oe | output | W | Output enables, 1 = drive |
| irq | output | 1 | Combined interrupt, OR of all status bits |

## Verification
The bench sweeps the end-of-interrupt write across the cycles around an edge's arrival. A design that gives clear priority over set would lose the interrupt in exactly one of those trials. Level-mode pins get end-of-interrupt writes while their input is active. A design that latched them, or let the write clear them, would show a wrong status or a stale `irq`. Disabled pins see edges, and the enable bit is cleared while an edge is pending. A design that captured while disabled or kept stale flags would raise `irq` later. Reads are issued right after the pins change, to catch a synchroniser that is one stage short or long. Writes also go to read-only and unmapped offsets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // byte offsets; the interrupt group begins at 0x30
  localparam int unsigned OFS_DOUT  = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_IEN   = 32'h30;
  localparam int unsigned OFS_ITYPE = 32'h34;
  localparam int unsigned OFS_IPOL  = 32'h38;
  localparam int unsigned OFS_ISTAT = 32'h3C;
  localparam int unsigned OFS_EOI   = 32'h40;
  localparam int unsigned OFS_EXT   = 32'h44;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DOUT,
    SEL_DIR,
    SEL_IEN,
    SEL_ITYPE,
    SEL_IPOL,
    SEL_ISTAT,
    SEL_EOI,
    SEL_EXT
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input int unsigned ofs);
    reg_sel_e s;
    case (ofs)
      OFS_DOUT:  s = SEL_DOUT;
      OFS_DIR:   s = SEL_DIR;
      OFS_IEN:   s = SEL_IEN;
      OFS_ITYPE: s = SEL_ITYPE;
      OFS_IPOL:  s = SEL_IPOL;
      OFS_ISTAT: s = SEL_ISTAT;
      OFS_EOI:   s = SEL_EOI;
      OFS_EXT:   s = SEL_EXT;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_sync
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= pad_in;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign pad_sync = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] itype,
  input  logic [W-1:0] ipol,
  input  logic [W-1:0] eoi_mask,
  output logic [W-1:0] status
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic prev_q;
      logic pend_q;
      logic rise, fall, hit, armed, lvl_on;

      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_sync[i];
      end

      assign rise  = pin_sync[i] & ~prev_q;
      assign fall  = ~pin_sync[i] & prev_q;
      assign armed = ien[i] & itype[i];
      assign hit   = armed & (ipol[i] ? rise : fall);

      // a new edge wins over a clear in the same cycle
      always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= ((pend_q & ~eoi_mask[i]) | hit) & armed;
      end

      assign lvl_on    = ien[i] & ~itype[i] & ~(pin_sync[i] ^ ipol[i]);
      assign status[i] = pend_q | lvl_on;
    end
  endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_sync,
  input  logic [W-1:0]  irq_status,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  ien_q,
  output logic [W-1:0]  itype_q,
  output logic [W-1:0]  ipol_q,
  output logic [W-1:0]  eoi_mask
);
  import gpio_irq_pkg::*;

  reg_sel_e     sel;
  logic [W-1:0] rd_mux;

  assign sel      = decode_sel(32'(bus_addr));
  assign eoi_mask = (bus_wr && sel == SEL_EOI) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DOUT:  dout_q  <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_IEN:   ien_q   <= bus_wdata;
        SEL_ITYPE: itype_q <= bus_wdata;
        SEL_IPOL:  ipol_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DOUT:  rd_mux = dout_q;
      SEL_DIR:   rd_mux = dir_q;
      SEL_IEN:   rd_mux = ien_q;
      SEL_ITYPE: rd_mux = itype_q;
      SEL_IPOL:  rd_mux = ipol_q;
      SEL_ISTAT: rd_mux = irq_status;
      SEL_EXT:   rd_mux = pin_sync;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int W           = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  gpio_in,
  output logic [W-1:0]  gpio_out,
  output logic [W-1:0]  gpio_oe,
  output logic          irq
);

  logic [W-1:0] pin_sync;
  logic [W-1:0] ien, itype, ipol, eoi_mask;
  logic [W-1:0] irq_status;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pad_in   (gpio_in),
    .pad_sync (pin_sync)
  );

  gpio_regs #(.W(W), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_sync   (pin_sync),
    .irq_status (irq_status),
    .dout_q     (gpio_out),
    .dir_q      (gpio_oe),
    .ien_q      (ien),
    .itype_q    (itype),
    .ipol_q     (ipol),
    .eoi_mask   (eoi_mask)
  );

  gpio_pin_irq #(.W(W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .pin_sync (pin_sync),
    .ien      (ien),
    .itype    (itype),
    .ipol     (ipol),
    .eoi_mask (eoi_mask),
    .status   (irq_status)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |irq_status;
  end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  gpio_out,
  input logic [W-1:0]  gpio_oe,
  input logic [W-1:0]  irq_status,
  input logic          irq
);
  import gpio_irq_pkg::*;

  localparam logic [AW-1:0] A_DOUT = AW'(OFS_DOUT);
  localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_EOI  = AW'(OFS_EOI);

  AST_DOUT_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DOUT) |=> (gpio_out == $past(bus_wdata))); // R2
  AST_DOUT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_DOUT) |=> $stable(gpio_out)); // R2
  AST_DIR_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DIR) |=> (gpio_oe == $past(bus_wdata))); // R3
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (irq_status != '0) |=> irq); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_status == '0) |=> !irq); // R11
  AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_EOI) |=> (bus_rdata == '0)); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R13

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .gpio_out   (gpio_out),
  .gpio_oe    (gpio_oe),
  .irq_status (irq_status),
  .irq        (irq)
);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

  localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h04, A_IEN = 8'h30, A_TYP = 8'h34,
                         A_POL = 8'h38, A_STA = 8'h3C, A_EOI = 8'h40, A_EXT = 8'h44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, gpio_out, gpio_oe;
  logic [31:0] pins = '0;
  logic        irq;

  always #10 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(pins),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_dout, m_dir, m_en, m_typ, m_pol, m_pend, m_rdata;
  logic        m_irq;
  logic [31:0] hist[$];   // pin samples, newest first
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic model_reset();
    m_dout = 0; m_dir = 0; m_en = 0; m_typ = 0; m_pol = 0; m_pend = 0;
    m_rdata = 0; m_irq = 0;
    hist = '{32'h0, 32'h0, 32'h0};
  endtask

  task automatic model_edge(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] lvl, old, stat, edges, eoi;
    if (rst) begin model_reset(); return; end
    lvl   = hist[1];
    old   = hist[2];
    stat  = m_pend | (m_en & ~m_typ & ~(lvl ^ m_pol));
    edges = (m_pol & lvl & ~old) | (~m_pol & ~lvl & old);
    eoi   = (w && a == A_EOI) ? d : 32'h0;
    m_irq = (stat != 0);
    if (r) begin
      case (a)
        A_DOUT: m_rdata = m_dout;
        A_DIR:  m_rdata = m_dir;
        A_IEN:  m_rdata = m_en;
        A_TYP:  m_rdata = m_typ;
        A_POL:  m_rdata = m_pol;
        A_STA:  m_rdata = stat;
        A_EXT:  m_rdata = lvl;
        default: m_rdata = 0;
      endcase
    end
    m_pend = ((m_pend & ~eoi) | (edges & m_en & m_typ)) & m_en & m_typ;
    if (w) begin
      case (a)
        A_DOUT: m_dout = d;
        A_DIR:  m_dir  = d;
        A_IEN:  m_en   = d;
        A_TYP:  m_typ  = d;
        A_POL:  m_pol  = d;
        default: ;
      endcase
    end
    hist.push_front(pins);
    void'(hist.pop_back());
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(w, r, a, d);
    @(negedge clk);
    chk("gpio_out", gpio_out, m_dout);
    chk("gpio_oe", gpio_oe, m_dir);
    chk("bus_rdata", bus_rdata, m_rdata);
    chk("irq", {31'h0, irq}, {31'h0, m_irq});
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); step(1, 0, a, d); endtask
  task automatic rd(input logic [7:0] a); step(0, 1, a, 0); endtask
  task automatic idle(input int n); for (int k = 0; k < n; k++) step(0, 0, 8'h0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist[10];
    alist = '{A_DOUT, A_DIR, A_IEN, A_TYP, A_POL, A_STA, A_EOI, A_EXT, 8'h08, 8'hFC};
    model_reset();
    idle(3);
    rst = 0;
    // R1: reset state and every register reads zero
    cur_req = "R1";
    idle(2);
    foreach (alist[k]) rd(alist[k]);

    cur_req = "R2";
    wr(A_DOUT, 32'hA5A5_0F0F); rd(A_DOUT);
    wr(A_DOUT, 32'hFFFF_FFFF); idle(2); wr(A_DOUT, 32'h0); rd(A_DOUT);

    cur_req = "R3";
    wr(A_DIR, 32'h0000_FFFF); rd(A_DIR); wr(A_DIR, 32'h8000_0001); rd(A_DIR);

    // R4: synchroniser delay; reads issued right after a change
    cur_req = "R4";
    pins = 32'h1234_5678; rd(A_EXT); rd(A_EXT); rd(A_EXT); rd(A_EXT);
    pins = 32'hFFFF_0000; idle(3); rd(A_EXT);
    pins = 32'h0; idle(3);

    // R5: rising edge on pin 0 latches
    cur_req = "R5";
    wr(A_TYP, 32'h0000_0107); wr(A_POL, 32'h0000_0113); wr(A_IEN, 32'h0000_0137);
    pins = 32'h1; idle(4); rd(A_STA);
    pins = 32'h0; idle(4); rd(A_STA);

    cur_req = "R8";
    pins = 32'h2; idle(4);          // pin 1 rising
    wr(A_EOI, 32'h2); rd(A_STA);    // only pin 1 cleared
    wr(A_EOI, 32'h1); idle(1); rd(A_STA);
    pins = 32'h0; idle(4);

    // R6: pin 2 falling-edge mode
    cur_req = "R6";
    pins = 32'h4; idle(4); rd(A_STA);
    pins = 32'h0; idle(4); rd(A_STA);
    wr(A_EOI, 32'h4); idle(2); rd(A_STA);

    // R7: pin 4 active high, pin 5 active low
    cur_req = "R7";
    idle(2); rd(A_STA);             // pin 5 low -> active
    pins = 32'h30; idle(4); rd(A_STA);
    wr(A_EOI, 32'h30); rd(A_STA);
    pins = 32'h0; idle(4); rd(A_STA);
    wr(A_IEN, 32'h0000_0107); idle(2); rd(A_STA);

    // R9: end-of-interrupt swept around an arriving edge on pin 8
    cur_req = "R9";
    for (int dly = 0; dly < 6; dly++) begin
      pins = 32'h0; idle(3); wr(A_EOI, 32'hFFFF_FFFF); idle(1);
      pins = 32'h100; idle(dly); wr(A_EOI, 32'h100); idle(3); rd(A_STA);
    end
    pins = 32'h0; wr(A_EOI, 32'hFFFF_FFFF); idle(3);

    // R10: pin 6 disabled edge; then disabling a pending pin
    cur_req = "R10";
    wr(A_TYP, 32'h0000_0147); wr(A_POL, 32'h0000_0153);
    pins = 32'h40; idle(4); rd(A_STA);
    pins = 32'h1; idle(4); rd(A_STA);
    wr(A_IEN, 32'h0000_0106); idle(2); rd(A_STA);
    wr(A_IEN, 32'h0000_0107); idle(2); rd(A_STA);
    pins = 32'h0; idle(3);

    // R12: read-only and unmapped offsets
    cur_req = "R12";
    wr(A_STA, 32'hFFFF_FFFF); wr(A_EXT, 32'hFFFF_FFFF); wr(8'h08, 32'hDEAD_BEEF);
    wr(8'hFC, 32'h1234_5678);
    foreach (alist[k]) rd(alist[k]);

    // R11 and R13: mixed traffic with random pins
    cur_req = "R11";
    for (int n = 0; n < 600; n++) begin
      int op;
      if (n % 5 == 0) pins = $urandom;
      op = $urandom_range(0, 3);
      if (op == 0)      wr(alist[$urandom_range(0, 9)], $urandom);
      else if (op == 1) rd(alist[$urandom_range(0, 9)]);
      else              idle(1);
      if (n == 300) cur_req = "R13";
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule